// File: doc/BRIEF.md
# DMA Channel Interrupt Coalescing Register File

This block holds the control and status state of a single DMA channel and decides when the channel interrupts the processor. Software reaches it through a plain 32-bit register port. The data mover gives it nothing but a one-cycle pulse for each finished packet. The block does not fetch descriptors or move data. It keeps the current-descriptor and tail-descriptor pointers for the engine, and it pulses the engine when software writes a new tail.

Interrupts are coalesced in two ways that work alongside each other. The first is a packet counter that reloads from a programmable threshold and flags an interrupt each time that many completions have arrived. The second is a delay timer that restarts on every completion and flags a second interrupt once traffic has been quiet for a programmable number of prescaled ticks. A status read shows the live counter and the live timer value. The interrupt line is the OR of the pending interrupt flags, each gated by its enable bit in the control register.

There is no streaming payload at this block's edge. Every pin is a plain level or a one-cycle pulse, so no handshake or back-pressure applies. Register reads are combinational from the address. Writes take effect at the clock edge where `reg_wr` is high.

Top module: `dma_irq_coalesce_regs`

## Requirements
- R1: After reset, control (offset 0x00) reads 0x0001_0000, status (offset 0x04) reads 0x0001_0001 (halted in bit 0, counter value 1 in bits 23:16), and irq, soft_rst and start_pulse are low.
- R2: Every control write without bit 2 stores the written word with bit 1 forced to 1.
- R3: A control write with bit 2 set does the following: raises soft_rst for exactly one cycle; sets control to 0x0001_0006 for that cycle and to 0x0001_0002 afterwards; leaves status with only halted set (counter 1, timer 0); and clears all interrupt flags and any running timer.
- R4: A control write with bit 0 set and bit 2 clear, outside a soft reset, clears both status bit 0 (halted) and status bit 1 (idle).
- R5: Each cpl_pulse decrements the coalescing counter. The pulse that finds the counter at 1 (or 0) sets status bit 12 and reloads the counter from control bits 23:16.
- R6: A cpl_pulse while control bits 31:24 hold a nonzero D restarts the delay timer at D. The timer decrements once every PRESCALE cycles. Exactly D×PRESCALE cycles after the last such pulse, it sets status bit 13 and reloads the coalescing counter from the threshold.
- R7: irq is high exactly when some bit of status 14:12 is set together with the same bit of control 14:12.
- R8: A status write clears each of bits 14:12 where the written data has a 1, and stores written bits 1:0 into idle and halted.
- R9: A status read returns the live timer count in bits 31:24, the live coalescing counter in bits 23:16, and zero in bits 15 and 11:2.
- R10: A write to the tail register (offset 0x10) stores the value, clears idle, and drives start_pulse high for exactly the following cycle.
- R11: The current-descriptor register (offset 0x08) reads back what was written. Reads of any other unmapped offset return 0, and writes to those offsets change no register.
- R12: Any control write reloads the coalescing counter from the newly written threshold. A completion pulse in the same cycle is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | AW | Byte address within the channel window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| cpl_pulse | input | 1 | One-cycle packet-completion pulse from the data mover |
| start_pulse | output | 1 | One-cycle start request to the descriptor engine |
| soft_rst | output | 1 | Channel soft reset, high for one cycle |
| irq | output | 1 | Channel interrupt |

## Verification
The bench builds the block with PRESCALE set to 2 and AW set to 6. The short prescaler puts every delay-timer expiry within a few cycles, so the bench can sweep delays 1 to 3 and check the exact expiry cycle arithmetically as D×2. It also sweeps thresholds 1 to 4 and checks the counter field after every single pulse. A timer restart in the middle of a countdown, a completion pulse in the same cycle as a control write, and a soft reset while the timer is running are each driven as separate scenarios.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  // Word indices inside one channel window (byte offset / 4)
  localparam logic [3:0] WI_CTRL = 4'd0;
  localparam logic [3:0] WI_STAT = 4'd1;
  localparam logic [3:0] WI_CUR  = 4'd2;
  localparam logic [3:0] WI_TAIL = 4'd4;

  localparam int CB_RUN    = 0;
  localparam int CB_TAILMD = 1;
  localparam int CB_SRST   = 2;
  localparam int FLD_LO    = 12;   // interrupt flag field 14:12
  localparam int THR_LO    = 16;   // threshold 23:16
  localparam int DLY_LO    = 24;   // delay 31:24

  localparam logic [31:0] CTRL_RST = 32'h0001_0000;
endpackage

// File: rtl/irq_coal_counter.sv
module irq_coal_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reload,
  input  logic [W-1:0] reload_val,
  input  logic         cpl,
  input  logic [W-1:0] thresh,
  output logic [W-1:0] cnt,
  output logic         hit
);
  localparam logic [W-1:0] ONE = W'(1);

  assign hit = cpl && !reload && (cnt <= ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= ONE;
    else if (reload)     cnt <= reload_val;
    else if (hit)        cnt <= thresh;
    else if (cpl)        cnt <= cnt - ONE;
  end

  assert_reload_on_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt == $past(thresh)));
endmodule

// File: rtl/irq_delay_timer.sv
module irq_delay_timer #(
  parameter int W        = 8,
  parameter int PRESCALE = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         expire
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pc;
  logic          tick;

  assign tick   = (pc == PLAST);
  assign expire = !clr && !load && (cnt == W'(1)) && tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      pc  <= '0;
    end else if (clr) begin
      cnt <= '0;
      pc  <= '0;
    end else if (load) begin
      cnt <= load_val;
      pc  <= '0;
    end else if (cnt != '0) begin
      if (tick) begin
        pc  <= '0;
        cnt <= cnt - W'(1);
      end else begin
        pc  <= pc + PW'(1);
      end
    end
  end

  assert_expire_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == '0));
endmodule

// File: rtl/dma_irq_coalesce_regs.sv
module dma_irq_coalesce_regs
  import dmairq_pkg::*;
#(
  parameter int AW       = 6,
  parameter int PRESCALE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          cpl_pulse,
  output logic          start_pulse,
  output logic          soft_rst,
  output logic          irq
);
  localparam int WW = AW - 2;

  logic [31:0] ctrl_q, cur_q, tail_q;
  logic        halt_q, idle_q, start_q;
  logic [2:0]  flg_q;
  logic [7:0]  coal_cnt, tmr_cnt;
  logic        coal_hit, tmr_exp;

  logic [WW-1:0] word;
  logic wr_ctrl, wr_stat, wr_cur, wr_tail, srst_wr, run_wr;
  logic [31:0] ctrl_wval;
  logic [2:0]  flg_n;
  logic        halt_n, idle_n;
  logic        unused_lsb;

  assign unused_lsb = ^reg_addr[1:0];
  assign word    = reg_addr[AW-1:2];
  assign wr_ctrl = reg_wr && (word == WW'(WI_CTRL));
  assign wr_stat = reg_wr && (word == WW'(WI_STAT));
  assign wr_cur  = reg_wr && (word == WW'(WI_CUR));
  assign wr_tail = reg_wr && (word == WW'(WI_TAIL));
  assign srst_wr = wr_ctrl && reg_wdata[CB_SRST];
  assign run_wr  = wr_ctrl && reg_wdata[CB_RUN] && !reg_wdata[CB_SRST] && !ctrl_q[CB_SRST];

  assign ctrl_wval = srst_wr ? (CTRL_RST | 32'h6) : (reg_wdata | 32'h2);

  irq_coal_counter #(.W(8)) u_coal (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload     (wr_ctrl || tmr_exp),
    .reload_val (wr_ctrl ? ctrl_wval[THR_LO+:8] : ctrl_q[THR_LO+:8]),
    .cpl        (cpl_pulse),
    .thresh     (ctrl_q[THR_LO+:8]),
    .cnt        (coal_cnt),
    .hit        (coal_hit)
  );

  irq_delay_timer #(.W(8), .PRESCALE(PRESCALE)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (srst_wr),
    .load     (cpl_pulse && (ctrl_q[DLY_LO+:8] != 8'd0)),
    .load_val (ctrl_q[DLY_LO+:8]),
    .cnt      (tmr_cnt),
    .expire   (tmr_exp)
  );

  always_comb begin
    flg_n  = flg_q;
    halt_n = halt_q;
    idle_n = idle_q;
    if (wr_stat) begin
      flg_n  = flg_q & ~reg_wdata[FLD_LO+:3];
      halt_n = reg_wdata[0];
      idle_n = reg_wdata[1];
    end
    if (coal_hit) flg_n[0] = 1'b1;
    if (tmr_exp)  flg_n[1] = 1'b1;
    if (wr_tail)  idle_n = 1'b0;
    if (run_wr) begin
      halt_n = 1'b0;
      idle_n = 1'b0;
    end
    if (srst_wr) begin
      flg_n  = '0;
      halt_n = 1'b1;
      idle_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      cur_q   <= '0;
      tail_q  <= '0;
      halt_q  <= 1'b1;
      idle_q  <= 1'b0;
      flg_q   <= '0;
      start_q <= 1'b0;
    end else begin
      if (wr_ctrl)      ctrl_q <= ctrl_wval;
      else              ctrl_q[CB_SRST] <= 1'b0;
      if (wr_cur)       cur_q  <= reg_wdata;
      if (wr_tail)      tail_q <= reg_wdata;
      halt_q  <= halt_n;
      idle_q  <= idle_n;
      flg_q   <= flg_n;
      start_q <= wr_tail;
    end
  end

  always_comb begin
    case (word)
      WW'(WI_CTRL): reg_rdata = ctrl_q;
      WW'(WI_STAT): reg_rdata = {tmr_cnt, coal_cnt, 1'b0, flg_q, 10'd0, idle_q, halt_q};
      WW'(WI_CUR):  reg_rdata = cur_q;
      WW'(WI_TAIL): reg_rdata = tail_q;
      default:      reg_rdata = '0;
    endcase
  end

  assign irq         = |(flg_q & ctrl_q[FLD_LO+:3]);
  assign soft_rst    = ctrl_q[CB_SRST];
  assign start_pulse = start_q;

  assert_tailmode_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_ctrl) |-> ctrl_q[CB_TAILMD]);
  assert_srst_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (halt_q && !idle_q && flg_q == 3'b000 && tmr_cnt == 8'd0));
  assert_irq_has_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flg_q != 3'b000));
  assert_start_from_tail_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> $past(reg_wr && reg_addr[AW-1:2] == WW'(WI_TAIL)));
  assert_flag_from_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flg_q[0]) |-> $past(coal_hit));
endmodule

// File: tb/test_dma_irq_coalesce_regs.sv
module test_dma_irq_coalesce_regs;
  localparam int P  = 2;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic cpl_pulse = 1'b0;
  logic start_pulse, soft_rst, irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dma_irq_coalesce_regs #(.AW(AW), .PRESCALE(P)) i_dma_irq_coalesce_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpl_pulse(cpl_pulse),
    .start_pulse(start_pulse), .soft_rst(soft_rst), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic with_cpl);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; cpl_pulse = with_cpl;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0; cpl_pulse = 1'b0;
  endtask

  task automatic pulse();
    cpl_pulse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cpl_pulse = 1'b0;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(6'h00, d); chk("R1 ctrl", d, 32'h0001_0000);
    rd(6'h04, d); chk("R1 status", d, 32'h0001_0001);
    chk("R1 pins", {29'd0, irq, soft_rst, start_pulse}, 32'd0);

    // R2 tail mode forced
    wr(6'h00, 32'h0000_0000, 1'b0);
    rd(6'h00, d); chk("R2 ctrl zero write", d, 32'h0000_0002);
    wr(6'h00, 32'h0000_0101, 1'b0);
    rd(6'h00, d); chk("R2 ctrl stored", d, 32'h0000_0103);

    // R4 run clears halted and idle; R8 direct bits
    wr(6'h04, 32'h0000_0003, 1'b0);
    rd(6'h04, d); chk("R8 status bits 1:0", d & 32'hFFFF, 32'h0000_0003);
    wr(6'h00, 32'h0001_7001, 1'b0);
    rd(6'h04, d); chk("R4 run clears", d, 32'h0001_0000);

    // R5 threshold sweep, R7 irq, R8 W1C, R9 counter field
    for (int t = 1; t <= 4; t++) begin
      wr(6'h00, (t << 16) | 32'h7001, 1'b0);
      for (int k = 1; k <= t; k++) begin
        pulse();
        rd(6'h04, d);
        if (k < t) begin
          chk("R5 no flag yet", {31'd0, d[12]}, 32'd0);
          chk("R9 counter field", {24'd0, d[23:16]}, t - k);
          chk("R7 irq low", {31'd0, irq}, 32'd0);
        end else begin
          chk("R5 flag set", {31'd0, d[12]}, 32'd1);
          chk("R5 reload", {24'd0, d[23:16]}, t);
          chk("R7 irq high", {31'd0, irq}, 32'd1);
        end
      end
      wr(6'h04, 32'h0000_1000, 1'b0);
      rd(6'h04, d); chk("R8 w1c bit12", {31'd0, d[12]}, 32'd0);
      chk("R7 irq after clear", {31'd0, irq}, 32'd0);
    end

    // R7 mask
    wr(6'h00, 32'h0001_0001, 1'b0);
    pulse();
    rd(6'h04, d); chk("R7 flag with mask off", {31'd0, d[12]}, 32'd1);
    chk("R7 masked irq", {31'd0, irq}, 32'd0);
    wr(6'h00, 32'h0001_1001, 1'b0);
    chk("R7 unmasked irq", {31'd0, irq}, 32'd1);
    wr(6'h04, 32'h0000_7000, 1'b0);
    chk("R8 w1c all", {31'd0, irq}, 32'd0);

    // R6 delay sweep
    for (int dl = 1; dl <= 3; dl++) begin
      wr(6'h00, (dl << 24) | 32'h0008_2001, 1'b0);
      pulse();
      rd(6'h04, d);
      chk("R9 timer field", {24'd0, d[31:24]}, dl);
      chk("R9 counter after pulse", {24'd0, d[23:16]}, 32'd7);
      repeat (dl * P - 1) @(negedge clk);
      rd(6'h04, d); chk("R6 not yet", {31'd0, d[13]}, 32'd0);
      @(negedge clk);
      rd(6'h04, d);
      chk("R6 expired", {31'd0, d[13]}, 32'd1);
      chk("R6 reload counter", {24'd0, d[23:16]}, 32'd8);
      chk("R9 timer zero", {24'd0, d[31:24]}, 32'd0);
      chk("R7 delay irq", {31'd0, irq}, 32'd1);
      wr(6'h04, 32'h0000_2000, 1'b0);
    end

    // R6 restart
    wr(6'h00, 32'h0308_2001, 1'b0);
    pulse();
    repeat (4) @(negedge clk);
    pulse();
    repeat (3 * P - 1) @(negedge clk);
    rd(6'h04, d); chk("R6 restart not yet", {31'd0, d[13]}, 32'd0);
    @(negedge clk);
    rd(6'h04, d); chk("R6 restart expired", {31'd0, d[13]}, 32'd1);
    wr(6'h04, 32'h0000_2000, 1'b0);

    // R12 control write reloads counter, simultaneous pulse ignored
    wr(6'h00, 32'h0003_1001, 1'b0);
    pulse();
    rd(6'h04, d); chk("R12 before", {24'd0, d[23:16]}, 32'd2);
    wr(6'h00, 32'h0003_1001, 1'b0);
    rd(6'h04, d); chk("R12 reload", {24'd0, d[23:16]}, 32'd3);
    wr(6'h00, 32'h0001_1001, 1'b1);
    rd(6'h04, d);
    chk("R12 same-cycle counter", {24'd0, d[23:16]}, 32'd1);
    chk("R12 same-cycle no flag", {31'd0, d[12]}, 32'd0);

    // R3 soft reset with timer running and flag pending
    wr(6'h00, 32'h0501_7001, 1'b0);
    pulse();
    wr(6'h00, 32'h0000_0004, 1'b0);
    chk("R3 soft_rst high", {31'd0, soft_rst}, 32'd1);
    rd(6'h00, d); chk("R3 ctrl during", d, 32'h0001_0006);
    rd(6'h04, d); chk("R3 status", d, 32'h0001_0001);
    chk("R3 irq", {31'd0, irq}, 32'd0);
    @(negedge clk);
    chk("R3 soft_rst low", {31'd0, soft_rst}, 32'd0);
    rd(6'h00, d); chk("R3 ctrl after", d, 32'h0001_0002);

    // R10 tail write
    wr(6'h04, 32'h0000_0002, 1'b0);
    wr(6'h10, 32'h0000_0100, 1'b0);
    chk("R10 start high", {31'd0, start_pulse}, 32'd1);
    rd(6'h04, d); chk("R10 idle cleared", {31'd0, d[1]}, 32'd0);
    rd(6'h10, d); chk("R10 tail value", d, 32'h0000_0100);
    @(negedge clk);
    chk("R10 start low", {31'd0, start_pulse}, 32'd0);

    // R11 descriptor and unmapped offsets
    wr(6'h08, 32'hDEAD_BEE0, 1'b0);
    rd(6'h08, d); chk("R11 cur", d, 32'hDEAD_BEE0);
    wr(6'h0C, 32'h1234_5678, 1'b0);
    rd(6'h0C, d); chk("R11 unmapped 0x0C", d, 32'd0);
    wr(6'h14, 32'hFFFF_FFFF, 1'b0);
    rd(6'h14, d); chk("R11 unmapped 0x14", d, 32'd0);
    rd(6'h08, d); chk("R11 cur kept", d, 32'hDEAD_BEE0);
    rd(6'h10, d); chk("R11 tail kept", d, 32'h0000_0100);
    rd(6'h00, d); chk("R11 ctrl kept", d, 32'h0001_0002);

    finish_run();
  end
endmodule